// File: doc/BRIEF.md
# Majority Voter with Spare Substitution

This block sits behind a pool of identical computing modules and turns their result words into one trusted word. A configurable number of modules take part in a bitwise majority vote, and a further set of modules is held offline as spares. Every cycle each voting member's word is compared with the voted word. A member that disagrees is retired for good, and the lowest-numbered unused spare is switched into its place. The spare is kept out of the vote for one cycle and then counts as a full member.

When no spare is left, a disagreeing member is simply dropped and the vote continues over the members that remain, with the majority threshold recomputed from their number. Once only two members are voting and they differ, the block raises a failure flag that stays set, and it stops reconfiguring itself. With three voting positions and one spare, two successive faults are masked before a third is reported as a failure.

All outputs are registered. The voted word, the map of selected modules, the count of unused spares and the failure flag all change one clock after the inputs that caused them.

Top module: `redundant_vote_pool`

## Requirements
- R1: After synchronous reset, modules 0 to N_ACT-1 vote, modules N_ACT and up are spares, `sel_map_o` has its low N_ACT bits set, `spares_left_o` equals N_SPARE, `fail_o` is 0 and `voted_o` is 0.
- R2: One cycle after the inputs are applied, bit b of `voted_o` is 1 exactly when more than half of the voting members have bit b set.
- R3: A voting member whose word differs from the voted word is retired permanently and never selected again.
- R4: Each retired member is replaced by the lowest-index unused spare. Bit i of `sel_map_o` is 1 while module i is voting or being switched in. At most N_ACT bits are set.
- R5: A spare switched in is excluded from the vote in its first selected cycle and joins the vote in the next cycle.
- R6: With no spare left, a disagreeing member is dropped, and the majority threshold is taken over the members that remain.
- R7: `spares_left_o` drops by the number of spares switched in and never rises.
- R8: When exactly two members vote and their words differ, `fail_o` is set one cycle later. It stays set and the selection no longer changes.
- R9: The words of spares, retired modules and a module in its switch-in cycle have no effect on `voted_o`.
- R10: With three voting positions and one spare, the voted word stays correct through two successive single-module faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_i | input | (N_ACT+N_SPARE)*W | Result words; module i at bits i*W and up |
| voted_o | output | W | Registered majority word |
| sel_map_o | output | N_ACT+N_SPARE | Modules currently selected |
| spares_left_o | output | $clog2(N_SPARE+1) | Unused spares |
| fail_o | output | 1 | Sticky failure flag |

## Verification
Majority is swept over every triple drawn from four words chosen so that all-agree, one-off, two-off and all-three-differ bit patterns arise. Each triple runs from a fresh reset, which tells apart a clean vote, a single replacement, and a replacement followed by a purge in the same cycle. A distinct garbage word on the spare shows that offline modules are ignored. A directed fault sequence then separates the switch-in cycle from full membership, a purge from a replacement, and a two-member agreement from the disagreement that raises the failure flag.

// File: rtl/rvp_pkg.sv
package rvp_pkg;
  typedef enum logic [1:0] {
    ST_SPARE = 2'd0,
    ST_FRESH = 2'd1,
    ST_VOTE  = 2'd2,
    ST_FAIL  = 2'd3
  } mod_st_t;
endpackage

// File: rtl/rvp_vote.sv
module rvp_vote #(
  parameter int W = 8,
  parameter int M = 4
) (
  input  logic [M*W-1:0]           words_i,
  input  logic [M-1:0]             mask_i,
  output logic [W-1:0]             maj_o,
  output logic [M-1:0]             dis_o,
  output logic [$clog2(M+1)-1:0]   pcnt_o
);
  localparam int CW = $clog2(M+1);

  always_comb begin
    pcnt_o = '0;
    for (int i = 0; i < M; i++) pcnt_o = pcnt_o + CW'(mask_i[i]);
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [CW-1:0] ones;
    always_comb begin
      ones = '0;
      for (int i = 0; i < M; i++) ones = ones + CW'(mask_i[i] & words_i[i*W+b]);
    end
    // twice the ones count against the member count
    assign maj_o[b] = ({1'b0, ones, 1'b0} > {2'b00, pcnt_o});
  end

  for (genvar i = 0; i < M; i++) begin : g_dis
    assign dis_o[i] = mask_i[i] && (words_i[i*W +: W] != maj_o);
  end
endmodule

// File: rtl/rvp_alloc.sv
module rvp_alloc
  import rvp_pkg::*;
#(
  parameter int M = 4
) (
  input  mod_st_t [M-1:0]          st_i,
  input  logic [M-1:0]             dis_i,
  input  logic [$clog2(M+1)-1:0]   pcnt_i,
  input  logic                     halt_i,
  output mod_st_t [M-1:0]          st_o,
  output logic                     fail_o
);
  localparam int CW = $clog2(M+1);

  logic [M-1:0] avail;
  logic         found;

  always_comb begin
    st_o   = st_i;
    fail_o = 1'b0;
    found  = 1'b0;
    for (int j = 0; j < M; j++) avail[j] = (st_i[j] == ST_SPARE);
    if (!halt_i) begin
      for (int i = 0; i < M; i++)
        if (st_i[i] == ST_FRESH) st_o[i] = ST_VOTE;
      if (pcnt_i == CW'(2) && (|dis_i)) begin
        fail_o = 1'b1;
      end else begin
        for (int i = 0; i < M; i++) begin
          if (dis_i[i]) begin
            st_o[i] = ST_FAIL;
            found   = 1'b0;
            for (int j = 0; j < M; j++) begin
              if (!found && avail[j]) begin
                st_o[j]  = ST_FRESH;
                avail[j] = 1'b0;
                found    = 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/redundant_vote_pool.sv
module redundant_vote_pool
  import rvp_pkg::*;
#(
  parameter int N_ACT   = 3,
  parameter int N_SPARE = 1,
  parameter int W       = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [(N_ACT+N_SPARE)*W-1:0]         res_i,
  output logic [W-1:0]                         voted_o,
  output logic [N_ACT+N_SPARE-1:0]             sel_map_o,
  output logic [$clog2(N_SPARE+1)-1:0]         spares_left_o,
  output logic                                 fail_o
);
  localparam int M  = N_ACT + N_SPARE;
  localparam int CW = $clog2(M+1);
  localparam int SW = $clog2(N_SPARE+1);

  mod_st_t [M-1:0] st_q, st_nxt;
  logic [M-1:0]    vote_mask, dis;
  logic [W-1:0]    maj;
  logic [CW-1:0]   pcnt;
  logic            fail_set;
  logic [M-1:0]    sel_nxt;
  logic [SW-1:0]   spares_nxt;

  always_comb
    for (int i = 0; i < M; i++) vote_mask[i] = (st_q[i] == ST_VOTE);

  rvp_vote #(.W(W), .M(M)) vote_i (
    .words_i(res_i), .mask_i(vote_mask),
    .maj_o(maj), .dis_o(dis), .pcnt_o(pcnt)
  );

  rvp_alloc #(.M(M)) alloc_i (
    .st_i(st_q), .dis_i(dis), .pcnt_i(pcnt), .halt_i(fail_o),
    .st_o(st_nxt), .fail_o(fail_set)
  );

  always_comb begin
    spares_nxt = '0;
    for (int i = 0; i < M; i++) begin
      sel_nxt[i] = (st_nxt[i] == ST_VOTE) || (st_nxt[i] == ST_FRESH);
      spares_nxt = spares_nxt + SW'(st_nxt[i] == ST_SPARE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < M; i++) begin
        if (i < N_ACT) begin
          st_q[i]      <= ST_VOTE;
          sel_map_o[i] <= 1'b1;
        end else begin
          st_q[i]      <= ST_SPARE;
          sel_map_o[i] <= 1'b0;
        end
      end
      voted_o       <= '0;
      spares_left_o <= SW'(N_SPARE);
      fail_o        <= 1'b0;
    end else begin
      st_q          <= st_nxt;
      voted_o       <= maj;
      sel_map_o     <= sel_nxt;
      spares_left_o <= spares_nxt;
      fail_o        <= fail_o | fail_set;
    end
  end

  // R7: spare count never rises
  a_r7_spares_no_rise: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (spares_left_o <= $past(spares_left_o)));
  // R4: never more selected modules than voting positions
  a_r4_sel_width: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_map_o) <= N_ACT);
  // R8: failure is sticky and freezes the selection
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> fail_o);
  a_r8_sel_frozen: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> $stable(sel_map_o));

  for (genvar i = 0; i < M; i++) begin : g_chk
    // R3: a retired module stays retired and unselected
    a_r3_retired_stays: assert property (@(posedge clk) disable iff (rst)
      (st_q[i] == ST_FAIL) |=> (st_q[i] == ST_FAIL) && !sel_map_o[i]);
    // R5: a switched-in spare joins the vote on the following cycle
    a_r5_fresh_joins: assert property (@(posedge clk) disable iff (rst)
      (st_q[i] == ST_FRESH) && !fail_o |=> (st_q[i] == ST_VOTE));
  end
endmodule

// File: tb/redundant_vote_pool_tb.sv
`timescale 1ns/1ps
module redundant_vote_pool_tb_top;
  localparam int N_ACT = 3, N_SPARE = 1, W = 8, M = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [M*W-1:0] res = '0;
  logic [W-1:0]   voted;
  logic [M-1:0]   sel;
  logic [0:0]     spl;
  logic           fail;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  redundant_vote_pool #(.N_ACT(N_ACT), .N_SPARE(N_SPARE), .W(W)) dut_i (
    .clk(clk), .rst(rst), .res_i(res), .voted_o(voted),
    .sel_map_o(sel), .spares_left_o(spl), .fail_o(fail)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  // drive at negedge, let one edge capture, sample at the next negedge
  task automatic step(input logic [7:0] a, b, c, d);
    res = {d, c, b, a};
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] vals [4];
    logic [7:0] mj;
    logic [3:0] f, esel;
    vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'h0F; vals[3] = 8'h35;

    do_reset();
    check("R1 voted", voted, 0);
    check("R1 sel", sel, 4'b0111);
    check("R1 spares", spl, 1);
    check("R1 fail", fail, 0);

    // sweep of majority over triples, spare holds a distinct word
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++) begin
          do_reset();
          step(vals[i], vals[j], vals[k], 8'hA5);
          mj = (vals[i] & vals[j]) | (vals[i] & vals[k]) | (vals[j] & vals[k]);
          f = {1'b0, vals[k] != mj, vals[j] != mj, vals[i] != mj};
          esel = (4'b0111 & ~f) | ((f != 0) ? 4'b1000 : 4'b0000);
          check("R2 R9 sweep voted", voted, mj);
          check("R3 R4 sweep sel", sel, esel);
          check("R7 sweep spares", spl, (f != 0) ? 0 : 1);
        end

    // directed fault sequence
    do_reset();
    step(8'h11, 8'h11, 8'h11, 8'h99);
    check("R9 spare ignored", voted, 8'h11);
    check("R2 clean sel", sel, 4'b0111);
    step(8'h22, 8'h5A, 8'h22, 8'h77);
    check("R10 first fault masked", voted, 8'h22);
    check("R4 spare 3 replaces 1", sel, 4'b1101);
    check("R7 spare used", spl, 0);
    step(8'h33, 8'h00, 8'h33, 8'hC3);
    check("R5 fresh spare excluded", voted, 8'h33);
    check("R5 fresh not retired", sel, 4'b1101);
    step(8'h44, 8'h00, 8'h44, 8'h44);
    check("R3 retired module ignored", voted, 8'h44);
    step(8'h55, 8'h00, 8'h66, 8'h66);
    check("R5 R10 joined spare outvotes", voted, 8'h66);
    check("R6 purge sel", sel, 4'b1100);
    check("R6 fail low", fail, 0);
    step(8'h00, 8'hFF, 8'h77, 8'h77);
    check("R6 two members agree", voted, 8'h77);
    check("R6 no fail", fail, 0);
    step(8'hFF, 8'hFF, 8'h0F, 8'hF0);
    check("R6 threshold of two", voted, 8'h00);
    check("R8 fail set", fail, 1);
    check("R8 sel kept", sel, 4'b1100);
    step(8'h00, 8'h00, 8'h12, 8'h34);
    check("R8 fail sticky", fail, 1);
    check("R8 sel frozen", sel, 4'b1100);
    check("R8 spares kept", spl, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule